// File: doc/BRIEF.md
# Oscillator Watchdog Clock Supervisor

This block checks an external oscillator against an always-running internal RC reference. It then decides which of the two clocks feeds the CPU and when the part may leave reset. Both clocks are modelled as one-cycle tick enables in a single fast reference domain. The block measures the oscillator by counting its ticks across a fixed span of RC ticks. An oscillator counts as healthy only when it is strictly faster than the RC reference, and only after two measurement spans in a row agree.

While the oscillator is unhealthy, the part is kept in reset and clocked from the RC source. Once the oscillator has been confirmed, a final reset delay runs on RC ticks. When that delay ends, reset is released and the CPU moves to the oscillator. A failing span in the delay or in normal operation sends the block back to the failure state.

A wake-up from power-down follows a separate path. The CPU clock enable is held low, because the first oscillator edges after a restart cannot be trusted. Any partly measured span is thrown away, and the clock comes back only after two fresh passing spans. No reset is applied on this path, so the state held through power-down is kept. A slow-down input passes only one CPU clock enable for every 32 source ticks.

Top module: `osc_watchdog`

## Requirements
- R1: After reset, sel_osc is 0 and hold_rst is 1.
- R2: A measurement span is WIN_TICKS rc_tick pulses long. A span passes only when more than WIN_TICKS osc_tick pulses fall inside it; a count equal to WIN_TICKS fails.
- R3: The block leaves the failure state only after two consecutive passing spans.
- R4: After confirmation, hold_rst stays 1 and sel_osc stays 0 for DELAY_TICKS further rc_tick pulses. Then hold_rst goes to 0 and sel_osc goes to 1.
- R5: A failing span during the reset delay or during oscillator operation returns the block to the failure state (hold_rst 1, sel_osc 0). The two-span confirmation and the full delay must then be repeated.
- R6: In the failure state with slow_mode 0, cpu_clk_en pulses once for each rc_tick.
- R7: In oscillator operation with slow_mode 0, cpu_clk_en pulses once for each osc_tick.
- R8: A pulse on pd_exit forces cpu_clk_en low, sel_osc 0 and hold_rst 0, and restarts the current span. After two consecutive passing spans, the block goes directly to oscillator operation with no reset delay. With a failing oscillator it stays gated.
- R9: With slow_mode 1, cpu_clk_en pulses once per 32 ticks of the selected source, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rc_tick | input | 1 | One-cycle pulse per internal RC clock period |
| osc_tick | input | 1 | One-cycle pulse per external oscillator period |
| pd_exit | input | 1 | One-cycle pulse marking exit from power-down |
| slow_mode | input | 1 | Divide the CPU clock enable by 32 |
| sel_osc | output | 1 | 1 when the CPU runs from the oscillator |
| cpu_clk_en | output | 1 | CPU clock enable pulse |
| hold_rst | output | 1 | Part held in reset |

## Verification
A stuck or misrouted state in this block is visible at the ports within one measurement span plus the reset delay. A supervisor that trusts a single passing span releases reset about one span too early. A delay counter that is not restarted releases reset while the oscillator is still being re-confirmed. The wake path is checked by counting cpu_clk_en pulses over windows shorter than two spans, which must count zero. The divider is checked by counting enables over a whole number of 32-tick periods, so the result does not depend on the divider's phase.

// File: rtl/osw_pkg.sv
package osw_pkg;
   typedef enum logic [1:0] {
      ST_FAIL  = 2'd0,
      ST_DELAY = 2'd1,
      ST_RUN   = 2'd2,
      ST_WAKE  = 2'd3
   } osw_state_e;
endpackage

// File: rtl/osw_freq_meter.sv
module osw_freq_meter #(
   parameter int WIN_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic rc_tick,
   input  logic osc_tick,
   output logic win_done,
   output logic win_pass
);
   localparam int RW = $clog2(WIN_TICKS);
   localparam int OW = $clog2(WIN_TICKS + 2);
   localparam logic [RW-1:0] RC_LAST  = RW'(WIN_TICKS - 1);
   localparam logic [OW-1:0] OSC_SAT  = OW'(WIN_TICKS + 1);

   if (WIN_TICKS < 2) begin : g_chk_win
      $error("osw_freq_meter: WIN_TICKS must be at least 2");
   end

   logic [RW-1:0] rc_cnt;
   logic [OW-1:0] osc_cnt;
   logic [OW-1:0] osc_next;

   always_comb begin
      osc_next = osc_cnt;
      if (osc_tick && (osc_cnt != OSC_SAT)) osc_next = osc_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rc_cnt   <= '0;
         osc_cnt  <= '0;
         win_done <= 1'b0;
         win_pass <= 1'b0;
      end else begin
         win_done <= 1'b0;
         if (restart) begin
            rc_cnt   <= '0;
            osc_cnt  <= '0;
            win_pass <= 1'b0;
         end else if (rc_tick && (rc_cnt == RC_LAST)) begin
            win_done <= 1'b1;
            win_pass <= (osc_next == OSC_SAT);
            rc_cnt   <= '0;
            osc_cnt  <= '0;
         end else begin
            if (rc_tick) rc_cnt <= rc_cnt + 1'b1;
            osc_cnt <= osc_next;
         end
      end
   end

   AST_WIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |=> !win_done); // R2
endmodule

// File: rtl/osw_ctrl.sv
module osw_ctrl
   import osw_pkg::*;
#(
   parameter int DELAY_TICKS = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pd_exit,
   input  logic       rc_tick,
   input  logic       win_done,
   input  logic       win_pass,
   output osw_state_e state,
   output logic       meter_restart
);
   localparam int DW = $clog2(DELAY_TICKS);
   localparam logic [DW-1:0] D_LAST = DW'(DELAY_TICKS - 1);

   if (DELAY_TICKS < 2) begin : g_chk_delay
      $error("osw_ctrl: DELAY_TICKS must be at least 2");
   end

   osw_state_e    st_q, st_d;
   logic [DW-1:0] dcnt_q, dcnt_d;
   logic          pass_seen_q, pass_seen_d;
   logic          confirm, bad_win;

   assign confirm       = win_done && win_pass && pass_seen_q;
   assign bad_win       = win_done && !win_pass;
   assign meter_restart = pd_exit;
   assign state         = st_q;

   always_comb begin
      st_d        = st_q;
      dcnt_d      = dcnt_q;
      pass_seen_d = win_done ? win_pass : pass_seen_q;
      if (pd_exit) begin
         st_d        = ST_WAKE;
         pass_seen_d = 1'b0;
      end else begin
         unique case (st_q)
            ST_FAIL: begin
               if (confirm) begin
                  st_d   = ST_DELAY;
                  dcnt_d = '0;
               end
            end
            ST_DELAY: begin
               if (bad_win) st_d = ST_FAIL;
               else if (rc_tick) begin
                  if (dcnt_q == D_LAST) st_d = ST_RUN;
                  else dcnt_d = dcnt_q + 1'b1;
               end
            end
            ST_RUN: begin
               if (bad_win) st_d = ST_FAIL;
            end
            ST_WAKE: begin
               if (confirm) st_d = ST_RUN;
            end
            default: st_d = ST_FAIL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_FAIL;
         dcnt_q      <= '0;
         pass_seen_q <= 1'b0;
      end else begin
         st_q        <= st_d;
         dcnt_q      <= dcnt_d;
         pass_seen_q <= pass_seen_d;
      end
   end

   AST_BAD_WINDOW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (win_done && !win_pass && !pd_exit) |=> (st_q == ST_FAIL || st_q == ST_WAKE)); // R5
   AST_WAKE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      pd_exit |=> (st_q == ST_WAKE)); // R8
endmodule

// File: rtl/osw_clk_gate.sv
module osw_clk_gate #(
   parameter int SLOW_DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_tick,
   input  logic gate_open,
   input  logic slow_mode,
   output logic cpu_clk_en
);
   if (SLOW_DIV < 1 || (SLOW_DIV & (SLOW_DIV - 1)) != 0) begin : g_chk_div
      $error("osw_clk_gate: SLOW_DIV must be a power of two");
   end

   if (SLOW_DIV == 1) begin : g_nodiv
      assign cpu_clk_en = gate_open && src_tick;
   end else begin : g_div
      localparam int DIVW = $clog2(SLOW_DIV);
      logic [DIVW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) div_q <= '0;
         else if (gate_open && src_tick) div_q <= div_q + 1'b1;
      end

      assign cpu_clk_en = gate_open && src_tick && (!slow_mode || (div_q == '0));

      AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
         (slow_mode && cpu_clk_en) |=> !cpu_clk_en); // R9
   end
endmodule

// File: rtl/osc_watchdog.sv
module osc_watchdog
   import osw_pkg::*;
#(
   parameter int WIN_TICKS   = 8,
   parameter int DELAY_TICKS = 1024,
   parameter int SLOW_DIV    = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rc_tick,
   input  logic osc_tick,
   input  logic pd_exit,
   input  logic slow_mode,
   output logic sel_osc,
   output logic cpu_clk_en,
   output logic hold_rst
);
   osw_state_e state;
   logic       meter_restart, win_done, win_pass;
   logic       gate_open, src_tick;

   osw_freq_meter #(.WIN_TICKS(WIN_TICKS)) u_meter (
      .clk(clk), .rst_n(rst_n), .restart(meter_restart),
      .rc_tick(rc_tick), .osc_tick(osc_tick),
      .win_done(win_done), .win_pass(win_pass)
   );

   osw_ctrl #(.DELAY_TICKS(DELAY_TICKS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .pd_exit(pd_exit), .rc_tick(rc_tick),
      .win_done(win_done), .win_pass(win_pass),
      .state(state), .meter_restart(meter_restart)
   );

   assign sel_osc   = (state == ST_RUN);
   assign hold_rst  = (state == ST_FAIL) || (state == ST_DELAY);
   assign gate_open = (state != ST_WAKE);
   assign src_tick  = sel_osc ? osc_tick : rc_tick;

   osw_clk_gate #(.SLOW_DIV(SLOW_DIV)) u_gate (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
      .gate_open(gate_open), .slow_mode(slow_mode), .cpu_clk_en(cpu_clk_en)
   );
endmodule

// File: tb/osc_watchdog_tb_top.sv
module osc_watchdog_tb_top;
   localparam int CLK_PER = 10;
   localparam int RC_PER  = 4;

   typedef struct packed {
      logic [7:0]  per;
      logic [15:0] cyc;
      logic        sel;
      logic        rst;
   } vec_t;

   // osc period in clocks (0 = no oscillator), wait, expected sel_osc, hold_rst
   localparam vec_t VEC [6] = '{
      '{8'd2, 16'd250, 1'b1, 1'b0},
      '{8'd8, 16'd100, 1'b0, 1'b1},
      '{8'd4, 16'd150, 1'b0, 1'b1},
      '{8'd3, 16'd250, 1'b1, 1'b0},
      '{8'd0, 16'd100, 1'b0, 1'b1},
      '{8'd2, 16'd250, 1'b1, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rc_tick = 1'b0, osc_tick = 1'b0, pd_exit = 1'b0, slow_mode = 1'b0;
   logic sel_osc, cpu_clk_en, hold_rst;
   int   osc_per = 0;
   int   rc_ph = 0, osc_ph = 0;
   int   total = 0, bad = 0;
   bit   finished = 0;

   always #(CLK_PER/2) clk = ~clk;

   osc_watchdog #(.WIN_TICKS(8), .DELAY_TICKS(16), .SLOW_DIV(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .rc_tick(rc_tick), .osc_tick(osc_tick),
      .pd_exit(pd_exit), .slow_mode(slow_mode),
      .sel_osc(sel_osc), .cpu_clk_en(cpu_clk_en), .hold_rst(hold_rst)
   );

   always @(negedge clk) begin
      if (rc_ph == RC_PER - 1) begin rc_ph = 0; rc_tick = 1'b1; end
      else begin rc_ph++; rc_tick = 1'b0; end
      if (osc_per == 0) begin osc_ph = 0; osc_tick = 1'b0; end
      else if (osc_ph >= osc_per - 1) begin osc_ph = 0; osc_tick = 1'b1; end
      else begin osc_ph++; osc_tick = 1'b0; end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic count_en(input int n, output int cnt);
      cnt = 0;
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
         if (cpu_clk_en) cnt++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wait_cyc(3);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse_pd();
      @(negedge clk);
      pd_exit = 1'b1;
      @(negedge clk);
      pd_exit = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PER * 150000);
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      finish_run();
   end

   initial begin
      int cnt;
      do_reset();
      #1;
      chk("R1 sel_osc after reset", sel_osc, 0);
      chk("R1 hold_rst after reset", hold_rst, 1);

      // vector table: R2 (equal fails, just-above passes), R3, R4, R5
      for (int i = 0; i < 6; i++) begin
         osc_per = VEC[i].per;
         wait_cyc(VEC[i].cyc);
         chk($sformatf("table row %0d R2 R4 R5 sel_osc", i), sel_osc, VEC[i].sel);
         chk($sformatf("table row %0d R2 R4 R5 hold_rst", i), hold_rst, VEC[i].rst);
      end

      // R7: running from oscillator, one enable per osc tick
      count_en(640, cnt);
      chk("R7 cpu_clk_en per osc tick", cnt, 320);
      // R9: slow mode divides by 32
      slow_mode = 1'b1;
      count_en(640, cnt);
      chk("R9 slow mode enable count", cnt, 10);
      slow_mode = 1'b0;

      // R8: wake-up gating with healthy oscillator
      pulse_pd();
      count_en(48, cnt);
      chk("R8 gated after wake", cnt, 0);
      chk("R8 no reset during wake", hold_rst, 0);
      chk("R8 rc selected during wake", sel_osc, 0);
      wait_cyc(150);
      chk("R8 oscillator after wake", sel_osc, 1);
      count_en(64, cnt);
      chk("R8 clock back after wake", cnt, 32);

      // R8: wake-up with dead oscillator stays gated
      osc_per = 0;
      pulse_pd();
      wait_cyc(200);
      count_en(64, cnt);
      chk("R8 dead osc stays gated", cnt, 0);
      chk("R8 dead osc no reset", hold_rst, 0);

      // R6: failure state clocks from RC
      do_reset();
      osc_per = 0;
      count_en(400, cnt);
      chk("R6 cpu_clk_en per rc tick", cnt, 100);

      // R3 R4: exact delay window from reset with fast oscillator
      do_reset();
      osc_per = 2;
      wait_cyc(115);
      chk("R3 R4 still in reset at 115", hold_rst, 1);
      chk("R3 R4 rc still selected at 115", sel_osc, 0);
      wait_cyc(35);
      chk("R4 released at 150", hold_rst, 0);
      chk("R4 oscillator selected at 150", sel_osc, 1);

      // R5: failing span during delay restarts the whole sequence
      do_reset();
      osc_per = 2;
      wait_cyc(80);
      osc_per = 0;
      wait_cyc(72);
      osc_per = 2;
      wait_cyc(100);
      chk("R5 delay restarted hold_rst", hold_rst, 1);
      wait_cyc(110);
      chk("R5 released after new delay", hold_rst, 0);
      chk("R5 oscillator after new delay", sel_osc, 1);

      finish_run();
   end
endmodule